// File: doc/BRIEF.md
# DMA Channel Register File and Transfer-End Interrupts

This block holds the programming state of a multi-channel DMA controller. It also produces the per-channel qualifiers and interrupt lines derived from that state. Software reaches the registers through a simple word-wide access port. Each channel owns a source pointer, a destination pointer, a transfer count and a control word. A single global operation word enables or disables the whole controller.

The transfer engine sits outside this block. It reads the qualifiers to decide which channels may run. When a channel has moved data, the engine posts the channel's new pointers and remaining count back here, together with a flag that marks the end of the transfer.

The transfer-end flag then holds the channel stopped. If the channel's interrupt enable is also set, the flag raises a level interrupt toward the system interrupt controller. The interrupt stays up until software clears either of the two bits.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, and all of `irq_o`, `chan_en_o` and `glob_en_o` are low.
- R2: Addresses are byte offsets, and only word-aligned ones are decoded. Channel n's registers sit at n*16 + k*4, where k=0 is source, k=1 is destination, k=2 is count and k=3 is control. The global operation word sits at offset 0x40. A read of any other offset returns zero, and a write to it changes nothing.
- R3: The count register keeps 24 bits (wdata[23:0]), and bits 31:24 always read as zero.
- R4: The control register keeps wdata[15:0], and bits 31:16 read as zero. Bit 0 is channel enable, bit 1 is transfer end and bit 2 is interrupt enable. The operation word likewise keeps 16 bits.
- R5: `chan_en_o[n]` is high exactly when control bits 1:0 of channel n equal 2'b01. A set transfer-end bit therefore blocks the channel.
- R6: `glob_en_o` is high exactly when bits 2:0 of the operation word equal 3'b001.
- R7: `irq_o[n]` is high exactly when control bits 2 and 1 of channel n are both set. It follows a control write on the next cycle, so it drops in the cycle after a write that leaves either bit clear.
- R8: A completion update (`upd_valid_i`) loads the addressed channel's source, destination and count from the update inputs. When `upd_end_i` is also high, it sets that channel's transfer-end bit, and the interrupt follows only if interrupt enable is set.
- R9: If a bus write and a completion update hit the same channel in one cycle, the update's source, destination and count win. The control word takes the bus value, except that the update's transfer-end set is forced on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the access port |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `bus_addr_i`, combinational |
| upd_valid_i | input | 1 | Completion update strobe from the engine |
| upd_chan_i | input | CH_W | Channel the update applies to |
| upd_src_i | input | 32 | New source pointer |
| upd_dst_i | input | 32 | New destination pointer |
| upd_cnt_i | input | 24 | Remaining transfer count |
| upd_end_i | input | 1 | Sets the transfer-end bit of the channel |
| chan_en_o | output | NUM_CH | Per-channel run qualifier |
| glob_en_o | output | 1 | Controller-wide run qualifier |
| irq_o | output | NUM_CH | Per-channel transfer-end interrupt, level |

## Verification
The properties assume that `upd_chan_i` names an existing channel whenever `upd_valid_i` is high. They also assume that every input is driven to a known value from reset onward. The stimulus drives all inputs on the falling edge and only ever picks channels 0 to 3. It leaves the update inputs idle except in the cycles where a completion is posted. The collision cases of R9 are therefore produced on purpose, in cycles where a bus write and an update name the same channel.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 24;
  localparam int CTL_W  = 16;
  localparam int OP_W   = 16;

  localparam int CTL_DE = 0;
  localparam int CTL_TE = 1;
  localparam int CTL_IE = 2;

  typedef enum logic [1:0] {
    REG_SRC = 2'd0,
    REG_DST = 2'd1,
    REG_CNT = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_reg_dec.sv
module dma_reg_dec
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 7,
  parameter int GLOB_OFS = NUM_CH * 16,
  localparam int IDX_W   = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] chan_hit_o,
  output reg_sel_e          reg_sel_o,
  output logic              glob_hit_o
);
  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned    = (addr_i[1:0] == 2'b00);
  assign idx        = addr_i[ADDR_W-1:4];
  assign reg_sel_o  = reg_sel_e'(addr_i[3:2]);
  assign glob_hit_o = (addr_i == ADDR_W'(GLOB_OFS));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
    assign chan_hit_o[n] = aligned && (idx == IDX_W'(n));
  end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              upd_i,
  input  logic              upd_end_i,
  input  logic [DATA_W-1:0] upd_src_i,
  input  logic [DATA_W-1:0] upd_dst_i,
  input  logic [CNT_W-1:0]  upd_cnt_i,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CTL_W-1:0]  ctl_o
);
  logic [CTL_W-1:0] ctl_d;

  // engine end flag overrides a simultaneous bus write of the control word
  always_comb begin
    ctl_d = wr_sel_i[REG_CTL] ? wdata_i[CTL_W-1:0] : ctl_o;
    if (upd_i && upd_end_i) ctl_d[CTL_TE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
      cnt_o <= '0;
      ctl_o <= '0;
    end else begin
      ctl_o <= ctl_d;
      if (upd_i) begin
        src_o <= upd_src_i;
        dst_o <= upd_dst_i;
        cnt_o <= upd_cnt_i;
      end else begin
        if (wr_sel_i[REG_SRC]) src_o <= wdata_i;
        if (wr_sel_i[REG_DST]) dst_o <= wdata_i;
        if (wr_sel_i[REG_CNT]) cnt_o <= wdata_i[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 7,
  parameter int GLOB_OFS = NUM_CH * 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       rd_data_o,
  input  logic              upd_valid_i,
  input  logic [CH_W-1:0]   upd_chan_i,
  input  logic [31:0]       upd_src_i,
  input  logic [31:0]       upd_dst_i,
  input  logic [23:0]       upd_cnt_i,
  input  logic              upd_end_i,
  output logic [NUM_CH-1:0] chan_en_o,
  output logic              glob_en_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] chan_hit;
  reg_sel_e          reg_sel;
  logic              glob_hit;
  logic [OP_W-1:0]   op_q;

  logic [DATA_W-1:0] src [NUM_CH];
  logic [DATA_W-1:0] dst [NUM_CH];
  logic [CNT_W-1:0]  cnt [NUM_CH];
  logic [CTL_W-1:0]  ctl [NUM_CH];

  dma_reg_dec #(
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .GLOB_OFS(GLOB_OFS)
  ) i_dec (
    .addr_i    (bus_addr_i),
    .chan_hit_o(chan_hit),
    .reg_sel_o (reg_sel),
    .glob_hit_o(glob_hit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [3:0] wr_sel;
    logic       upd_hit;

    for (genvar k = 0; k < 4; k++) begin : g_sel
      assign wr_sel[k] = bus_we_i && chan_hit[n] && (reg_sel == reg_sel_e'(k));
    end
    assign upd_hit = upd_valid_i && (upd_chan_i == CH_W'(n));

    dma_chan_slot i_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_sel_i (wr_sel),
      .wdata_i  (bus_wdata_i),
      .upd_i    (upd_hit),
      .upd_end_i(upd_end_i),
      .upd_src_i(upd_src_i),
      .upd_dst_i(upd_dst_i),
      .upd_cnt_i(upd_cnt_i),
      .src_o    (src[n]),
      .dst_o    (dst[n]),
      .cnt_o    (cnt[n]),
      .ctl_o    (ctl[n])
    );

    assign chan_en_o[n] = ctl[n][CTL_DE] && !ctl[n][CTL_TE];
    assign irq_o[n]     = ctl[n][CTL_IE] && ctl[n][CTL_TE];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   op_q <= '0;
    else if (bus_we_i && glob_hit) op_q <= bus_wdata_i[OP_W-1:0];
  end

  assign glob_en_o = (op_q[2:0] == 3'b001);

  always_comb begin
    rd_data_o = '0;
    if (glob_hit) rd_data_o = {{(DATA_W-OP_W){1'b0}}, op_q};
    for (int n = 0; n < NUM_CH; n++) begin
      if (chan_hit[n]) begin
        unique case (reg_sel)
          REG_SRC: rd_data_o = src[n];
          REG_DST: rd_data_o = dst[n];
          REG_CNT: rd_data_o = {{(DATA_W-CNT_W){1'b0}}, cnt[n]};
          REG_CTL: rd_data_o = {{(DATA_W-CTL_W){1'b0}}, ctl[n]};
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 7,
  parameter int GLOB_OFS = NUM_CH * 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       rd_data_o,
  input logic              upd_valid_i,
  input logic [CH_W-1:0]   upd_chan_i,
  input logic              upd_end_i,
  input logic [NUM_CH-1:0] chan_en_o,
  input logic              glob_en_o,
  input logic [NUM_CH-1:0] irq_o
);
  logic op_wr;
  assign op_wr = bus_we_i && (bus_addr_i == ADDR_W'(GLOB_OFS));

  a_r6_glob_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_wr && bus_wdata_i[2:0] == 3'b001) |=> glob_en_o);
  a_r6_glob_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_wr && bus_wdata_i[2:0] != 3'b001) |=> !glob_en_o);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    logic ctl_wr, cnt_rd, end_hit;
    assign ctl_wr  = bus_we_i && (bus_addr_i == ADDR_W'(n * 16 + 12));
    assign cnt_rd  = (bus_addr_i == ADDR_W'(n * 16 + 8));
    assign end_hit = upd_valid_i && (upd_chan_i == CH_W'(n)) && upd_end_i;

    a_r7_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_wr && bus_wdata_i[2:1] != 2'b11 && !end_hit) |=> !irq_o[n]);
    a_r7_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_wr && bus_wdata_i[2:1] == 2'b11) |=> irq_o[n]);
    a_r8_end_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_hit |=> !chan_en_o[n]);
    a_r5_irq_not_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> !chan_en_o[n]);
    a_r3_cnt_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_rd |-> (rd_data_o[31:24] == 8'h00));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
  .NUM_CH  (NUM_CH),
  .ADDR_W  (ADDR_W),
  .GLOB_OFS(GLOB_OFS)
) i_chk (.*);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        uv = 1'b0;
  logic [1:0]  uch = '0;
  logic [31:0] us = '0, ud = '0;
  logic [23:0] uc = '0;
  logic        ue = 1'b0;
  logic [3:0]  en, irq;
  logic        gen;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_src [NCH];
  logic [31:0] m_dst [NCH];
  logic [23:0] m_cnt [NCH];
  logic [15:0] m_ctl [NCH];
  logic [15:0] m_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .rd_data_o(rdata), .upd_valid_i(uv),
    .upd_chan_i(uch), .upd_src_i(us), .upd_dst_i(ud), .upd_cnt_i(uc),
    .upd_end_i(ue), .chan_en_o(en), .glob_en_o(gen), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [6:0] a);
    int ch, k;
    if (a == 7'h40) return {16'h0, m_op};
    if (a >= 7'h40 || a[1:0] != 0) return 0;
    ch = int'(a) / 16;
    k  = (int'(a) % 16) / 4;
    case (k)
      0: return m_src[ch];
      1: return m_dst[ch];
      2: return {8'h0, m_cnt[ch]};
      default: return {16'h0, m_ctl[ch]};
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NCH; i++) begin
      m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0;
    end
    m_op = 0;
  endtask

  task automatic m_clock();
    if (we) begin
      if (addr == 7'h40) m_op = wdata[15:0];
      else if (addr < 7'h40 && addr[1:0] == 0) begin
        int ch = int'(addr) / 16;
        case ((int'(addr) % 16) / 4)
          0: m_src[ch] = wdata;
          1: m_dst[ch] = wdata;
          2: m_cnt[ch] = wdata[23:0];
          default: m_ctl[ch] = wdata[15:0];
        endcase
      end
    end
    if (uv) begin
      m_src[uch] = us; m_dst[uch] = ud; m_cnt[uch] = uc;
      if (ue) m_ctl[uch][1] = 1'b1;
    end
  endtask

  task automatic cmp_outputs();
    for (int i = 0; i < NCH; i++) begin
      check(en[i] == (m_ctl[i][1:0] == 2'b01), "R5 chan_en", 32'(en[i]), 32'(m_ctl[i][1:0] == 2'b01));
      check(irq[i] == (m_ctl[i][2] && m_ctl[i][1]), "R7 irq", 32'(irq[i]), 32'(m_ctl[i][2] && m_ctl[i][1]));
    end
    check(gen == (m_op[2:0] == 3'b001), "R6 glob_en", 32'(gen), 32'(m_op[2:0] == 3'b001));
  endtask

  // one clock: drive at negedge, check read, clock, check outputs
  task automatic step();
    #1;
    check(rdata == m_read(addr), "R2 read", rdata, m_read(addr));
    @(posedge clk);
    m_clock();
    @(negedge clk);
    cmp_outputs();
    we = 0; uv = 0; ue = 0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d; step();
  endtask

  task automatic upd(input logic [1:0] c, input logic [31:0] s, input logic [31:0] d,
                     input logic [23:0] n, input logic e);
    uv = 1; uch = c; us = s; ud = d; uc = n; ue = e;
  endtask

  task automatic expect_rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1;
    check(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    m_reset();
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cmp_outputs();
    for (int a = 0; a < 128; a += 4) expect_rd(7'(a), 32'h0, "R1 reset value");
    check(irq == 4'h0 && en == 4'h0 && gen == 1'b0, "R1 outputs", {27'h0, gen, irq}, 32'h0);

    // R2 address map
    for (int c = 0; c < NCH; c++) begin
      wr(7'(c*16 + 0), 32'hA000_0000 + c);
      wr(7'(c*16 + 4), 32'hB000_0000 + c);
      wr(7'(c*16 + 8), 32'h0012_3400 + c);
    end
    expect_rd(7'h24, 32'hB000_0002, "R2 ch2 dst");
    expect_rd(7'h30, 32'hA000_0003, "R2 ch3 src");
    // R3 count width
    wr(7'h18, 32'hFFFF_FFFF);
    expect_rd(7'h18, 32'h00FF_FFFF, "R3 count masked");
    // R4 control width
    wr(7'h0C, 32'hFFFF_FFF8);
    expect_rd(7'h0C, 32'h0000_FFF8, "R4 control masked");
    // R2 unmapped
    wr(7'h44, 32'hDEAD_BEEF);
    wr(7'h01, 32'hDEAD_BEEF);
    wr(7'h7C, 32'hDEAD_BEEF);
    expect_rd(7'h44, 32'h0, "R2 unmapped read");
    expect_rd(7'h00, 32'hA000_0000, "R2 unmapped write no effect");
    expect_rd(7'h40, 32'h0, "R2 op untouched");

    // R5 enable qualifier
    wr(7'h1C, 32'h1);
    check(en[1] == 1'b1, "R5 en set", 32'(en[1]), 32'h1);
    wr(7'h1C, 32'h3);
    check(en[1] == 1'b0, "R5 te blocks", 32'(en[1]), 32'h0);
    // R6 global enable
    wr(7'h40, 32'h1);  check(gen == 1'b1, "R6 001", 32'(gen), 32'h1);
    wr(7'h40, 32'h3);  check(gen == 1'b0, "R6 011", 32'(gen), 32'h0);
    wr(7'h40, 32'h9);  check(gen == 1'b1, "R6 1001", 32'(gen), 32'h1);
    wr(7'h40, 32'h5);  check(gen == 1'b0, "R6 101", 32'(gen), 32'h0);

    // R8 completion with interrupt enable
    wr(7'h2C, 32'h5);
    upd(2'd2, 32'h1111_0000, 32'h2222_0000, 24'h0, 1'b1); addr = 7'h28; step();
    check(irq[2] == 1'b1, "R8 irq raised", 32'(irq[2]), 32'h1);
    expect_rd(7'h2C, 32'h7, "R8 te set");
    expect_rd(7'h20, 32'h1111_0000, "R8 src loaded");
    // R7 clearing TE drops irq
    wr(7'h2C, 32'h5);
    check(irq[2] == 1'b0, "R7 te clear drops", 32'(irq[2]), 32'h0);
    wr(7'h2C, 32'h7);
    check(irq[2] == 1'b1, "R7 set by write", 32'(irq[2]), 32'h1);
    wr(7'h2C, 32'h3);
    check(irq[2] == 1'b0, "R7 ie clear drops", 32'(irq[2]), 32'h0);

    // R8 completion without IE, and without end flag
    wr(7'h3C, 32'h1);
    upd(2'd3, 32'h5, 32'h6, 24'h10, 1'b0); addr = 7'h38; step();
    expect_rd(7'h3C, 32'h1, "R8 no end keeps te");
    expect_rd(7'h38, 32'h10, "R8 count loaded");
    upd(2'd3, 32'h7, 32'h8, 24'h0, 1'b1); addr = 7'h3C; step();
    check(irq[3] == 1'b0, "R8 no ie no irq", 32'(irq[3]), 32'h0);
    expect_rd(7'h3C, 32'h3, "R8 te set no ie");

    // R9 collisions
    upd(2'd1, 32'hCAFE_0001, 32'h0, 24'h0, 1'b0); wr(7'h10, 32'h1234_5678);
    expect_rd(7'h10, 32'hCAFE_0001, "R9 engine wins src");
    upd(2'd0, 32'h0, 32'h0, 24'h0, 1'b1); wr(7'h0C, 32'h4);
    expect_rd(7'h0C, 32'h6, "R9 te forced over write");
    check(irq[0] == 1'b1, "R9 irq after collision", 32'(irq[0]), 32'h1);
    upd(2'd0, 32'h0, 32'h0, 24'h0, 1'b1); wr(7'h1C, 32'h4);
    expect_rd(7'h1C, 32'h4, "R9 other channel plain write");

    repeat (3) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule